// File: doc/BRIEF.md
# Branch Trace Store Logger

This block turns control-flow events (taken branches, interrupts and exceptions) into 64-bit trace records. Each record holds the source address and the target address of one event. The records can go to two places, and separate control bits turn each path on. One path sends every record out on a message port in the cycle after the event. The other path writes records into a buffer in memory through a simple valid/ready write request.

The buffer is described by three internal registers: a base, an absolute maximum and a current index. The index moves forward by eight bytes for each stored record. A mode bit sets what happens when the index reaches the maximum. In one mode the index returns to the base and older records are overwritten. In the other mode, storing stops and an interrupt request is raised, and it stays raised until software clears it.

Only one memory write can be outstanding at a time. An event that would need a second write while the first is still waiting is dropped, and the drop is counted.

Top module: `btrace_logger`

## Requirements
- R1: After reset, `mem_valid`, `msg_valid` and `irq` are low, `ovf_count` is zero, and the first stored record is written to address `RESET_BASE`.
- R2: When `trace_en` is high and any bit of `ev_strobe` is high, `msg_valid` is high in the next cycle and `msg_data` holds `{ev_to, ev_from}`, with the target address in bits 63:32. With `trace_en` low, no message is produced.
- R3: When `store_en` is high, an event is present and the buffer has room, `mem_valid` rises in the next cycle with `mem_addr` equal to the current index and `mem_data` equal to `{ev_to, ev_from}`.
- R4: With `store_en` low, an event produces no write request.
- R5: Each stored record moves the index forward by 8, so consecutive records go to consecutive 8-byte slots.
- R6: While `mem_valid` is high and `mem_ready` is low, the request stays up and `mem_addr` and `mem_data` do not change.
- R7: A store event that arrives while a request is waiting (and `mem_ready` is low) is dropped. The waiting request is unchanged, the index does not advance, and `ovf_count` goes up by one, saturating at its maximum.
- R8: With `irq_on_full` high, the store that brings the index up to the maximum raises `irq` in the same cycle as its request. After that, store events produce no request and are not counted as drops.
- R9: Once raised, `irq` stays high until `irq_clr` is pulsed, and then it goes low.
- R10: With `irq_on_full` low, the store in the last slot before the maximum is followed by a store at the base, and `irq` is never raised.
- R11: A `cfg_load` pulse loads the base and the maximum, and sets the index to the new base, which makes room for storing again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Enable the trace message output |
| store_en | input | 1 | Enable writing records to the buffer |
| irq_on_full | input | 1 | 1: stop and interrupt at the maximum; 0: wrap to the base |
| ev_strobe | input | 3 | Event strobes: bit 0 branch, bit 1 interrupt, bit 2 exception |
| ev_from | input | VA_W | Source address of the event |
| ev_to | input | VA_W | Target address of the event |
| cfg_load | input | 1 | Load base and maximum; index set to base |
| cfg_base | input | AW | New buffer base |
| cfg_max | input | AW | New absolute buffer maximum |
| irq_clr | input | 1 | Clear the full interrupt |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | AW | Write byte address |
| mem_data | output | 2*VA_W | Record being written |
| msg_valid | output | 1 | Trace message valid, one cycle |
| msg_data | output | 2*VA_W | Trace message record |
| irq | output | 1 | Buffer-full interrupt request |
| ovf_count | output | OVF_W | Count of dropped store events, saturating |

## Verification
The index cannot be read directly, so a wrong index shows up at `mem_addr` on the next stored record. A missing wrap or a wrong step therefore appears at most one record after the faulty update. A fill point that is off by one shows up as `irq` rising one record too early or too late, or as a request that should have been suppressed. A bad pending flag or hold register shows up within a cycle, either as a request that changes while stalled or as a drop that is counted when it should not be (or not counted when it should). The directed scenarios place every record address and every `irq` edge at a known cycle.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
    localparam int REC_BYTES = 8;

    typedef enum logic {
        BUF_WRAP = 1'b0,
        BUF_STOP = 1'b1
    } buf_mode_e;
endpackage

// File: rtl/btrace_index.sv
module btrace_index
    import btrace_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] RESET_BASE = 32'h0,
    parameter logic [31:0] RESET_MAX  = 32'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_max,
    input  logic          adv,
    input  buf_mode_e     mode,
    input  logic          irq_clr,
    output logic [AW-1:0] idx,
    output logic          room,
    output logic          irq
);
    localparam logic [AW-1:0] STEP = AW'(REC_BYTES);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] lim;
        logic [AW-1:0] idx;
        logic          irq;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [AW-1:0] nxt;
    logic          hit_end;

    always_comb begin
        st_d    = st_q;
        nxt     = st_q.idx + STEP;
        hit_end = (nxt >= st_q.lim);
        if (irq_clr) begin
            st_d.irq = 1'b0;
        end
        if (adv) begin
            if (mode == BUF_WRAP && hit_end) begin
                st_d.idx = st_q.base;
            end else begin
                st_d.idx = nxt;
            end
            if (mode == BUF_STOP && hit_end) begin
                st_d.irq = 1'b1;
            end
        end
        if (cfg_load) begin
            st_d.base = cfg_base;
            st_d.lim  = cfg_max;
            st_d.idx  = cfg_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base <= RESET_BASE[AW-1:0];
            st_q.lim  <= RESET_MAX[AW-1:0];
            st_q.idx  <= RESET_BASE[AW-1:0];
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx  = st_q.idx;
    assign room = !(mode == BUF_STOP && st_q.idx >= st_q.lim);
    assign irq  = st_q.irq;
endmodule

// File: rtl/btrace_wq.sv
module btrace_wq #(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic [AW-1:0]    addr_in,
    input  logic [DW-1:0]    rec_in,
    input  logic             mem_ready,
    output logic             take,
    output logic             mem_valid,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic [OVF_W-1:0] ovf_count
);
    localparam logic [OVF_W-1:0] OVF_TOP = '1;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [OVF_W-1:0] ovf;
    } wq_t;

    wq_t  st_d, st_q;
    logic free;
    logic drop;

    always_comb begin
        free = !st_q.vld || mem_ready;
        take = want && free;
        drop = want && !free;
        st_d = st_q;
        if (st_q.vld && mem_ready) begin
            st_d.vld = 1'b0;
        end
        if (take) begin
            st_d.vld  = 1'b1;
            st_d.addr = addr_in;
            st_d.data = rec_in;
        end
        if (drop && st_q.ovf != OVF_TOP) begin
            st_d.ovf = st_q.ovf + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid = st_q.vld;
    assign mem_addr  = st_q.addr;
    assign mem_data  = st_q.data;
    assign ovf_count = st_q.ovf;
endmodule

// File: rtl/btrace_msg.sv
module btrace_msg #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [DW-1:0] rec_in,
    output logic          msg_valid,
    output logic [DW-1:0] msg_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } msg_t;

    msg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        if (fire) begin
            st_d.data = rec_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid = st_q.vld;
    assign msg_data  = st_q.data;
endmodule

// File: rtl/btrace_logger.sv
module btrace_logger
    import btrace_pkg::*;
#(
    parameter int          VA_W       = 32,
    parameter int          AW         = 32,
    parameter int          OVF_W      = 8,
    parameter logic [31:0] RESET_BASE = 32'h0,
    parameter logic [31:0] RESET_MAX  = 32'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trace_en,
    input  logic               store_en,
    input  logic               irq_on_full,
    input  logic [2:0]         ev_strobe,
    input  logic [VA_W-1:0]    ev_from,
    input  logic [VA_W-1:0]    ev_to,
    input  logic               cfg_load,
    input  logic [AW-1:0]      cfg_base,
    input  logic [AW-1:0]      cfg_max,
    input  logic               irq_clr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [AW-1:0]      mem_addr,
    output logic [2*VA_W-1:0]  mem_data,
    output logic               msg_valid,
    output logic [2*VA_W-1:0]  msg_data,
    output logic               irq,
    output logic [OVF_W-1:0]   ovf_count
);
    localparam int DW = 2 * VA_W;

    logic          ev_any;
    logic [DW-1:0] rec;
    logic [AW-1:0] idx;
    logic          room;
    logic          want;
    logic          take;
    buf_mode_e     mode;

    assign ev_any = |ev_strobe;
    assign rec    = {ev_to, ev_from};
    assign mode   = irq_on_full ? BUF_STOP : BUF_WRAP;
    assign want   = ev_any && store_en && room;

    btrace_index #(
        .AW(AW), .RESET_BASE(RESET_BASE), .RESET_MAX(RESET_MAX)
    ) u_index (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_max(cfg_max), .adv(take), .mode(mode), .irq_clr(irq_clr),
        .idx(idx), .room(room), .irq(irq)
    );

    btrace_wq #(.AW(AW), .DW(DW), .OVF_W(OVF_W)) u_wq (
        .clk(clk), .rst_n(rst_n), .want(want), .addr_in(idx), .rec_in(rec),
        .mem_ready(mem_ready), .take(take), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .ovf_count(ovf_count)
    );

    btrace_msg #(.DW(DW)) u_msg (
        .clk(clk), .rst_n(rst_n), .fire(ev_any && trace_en), .rec_in(rec),
        .msg_valid(msg_valid), .msg_data(msg_data)
    );
endmodule

// File: rtl/btrace_logger_chk.sv
module btrace_logger_chk #(
    parameter int VA_W = 32,
    parameter int AW   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trace_en,
    input logic              store_en,
    input logic              irq_on_full,
    input logic [2:0]        ev_strobe,
    input logic [VA_W-1:0]   ev_from,
    input logic [VA_W-1:0]   ev_to,
    input logic              irq_clr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [AW-1:0]     mem_addr,
    input logic [2*VA_W-1:0] mem_data,
    input logic              msg_valid,
    input logic [2*VA_W-1:0] msg_data,
    input logic              irq
);
    AST_MSG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_strobe && trace_en) |=> (msg_valid && msg_data == $past({ev_to, ev_from}))); // R2
    AST_MSG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ev_strobe && trace_en) |=> !msg_valid); // R2
    AST_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_valid || mem_ready) && !(|ev_strobe && store_en)) |=> !mem_valid); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R9
    AST_WRAP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_on_full) |=> !irq); // R10
endmodule

bind btrace_logger btrace_logger_chk #(.VA_W(VA_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .store_en(store_en),
    .irq_on_full(irq_on_full), .ev_strobe(ev_strobe), .ev_from(ev_from),
    .ev_to(ev_to), .irq_clr(irq_clr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .msg_valid(msg_valid), .msg_data(msg_data), .irq(irq)
);

// File: tb/btrace_logger_bench.sv
module btrace_logger_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0, store_en = 1'b0, irq_on_full = 1'b0;
    logic [2:0]  ev_strobe = '0;
    logic [31:0] ev_from = '0, ev_to = '0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_base = '0, cfg_max = '0;
    logic        irq_clr = 1'b0;
    logic        mem_ready = 1'b0;
    logic        mem_valid, msg_valid, irq;
    logic [31:0] mem_addr;
    logic [63:0] mem_data, msg_data;
    logic [7:0]  ovf_count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    btrace_logger u_btrace_logger (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .store_en(store_en),
        .irq_on_full(irq_on_full), .ev_strobe(ev_strobe), .ev_from(ev_from),
        .ev_to(ev_to), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_max(cfg_max), .irq_clr(irq_clr), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .msg_valid(msg_valid), .msg_data(msg_data), .irq(irq),
        .ovf_count(ovf_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic event_in(input logic [2:0] s, input logic [31:0] f, input logic [31:0] t);
        @(negedge clk);
        ev_strobe = s; ev_from = f; ev_to = t;
        @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic complete();
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic load_buf(input logic [31:0] b, input logic [31:0] m);
        @(negedge clk);
        cfg_load = 1'b1; cfg_base = b; cfg_max = m;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mem_valid", 64'(mem_valid), 64'd0);
        check("R1 msg_valid", 64'(msg_valid), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 ovf", 64'(ovf_count), 64'd0);
        store_en = 1'b1;
        event_in(3'b001, 32'hAAAA_0000, 32'hBBBB_0000);
        check("R1 first addr", 64'(mem_addr), 64'h0);
        complete();
        store_en = 1'b0;
    endtask

    task automatic t_msg();
        trace_en = 1'b1;
        event_in(3'b010, 32'h1111_2222, 32'h3333_4444);
        check("R2 msg_valid", 64'(msg_valid), 64'd1);
        check("R2 msg_data", msg_data, 64'h3333_4444_1111_2222);
        @(negedge clk);
        check("R2 one pulse", 64'(msg_valid), 64'd0);
        trace_en = 1'b0;
        event_in(3'b100, 32'h5, 32'h6);
        check("R2 disabled", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_store();
        load_buf(32'h1000, 32'h1020);
        check("R11 load idle", 64'(mem_valid), 64'd0);
        store_en = 1'b1;
        event_in(3'b001, 32'h0000_1234, 32'h0000_5678);
        check("R3 valid", 64'(mem_valid), 64'd1);
        check("R3 addr", 64'(mem_addr), 64'h1000);
        check("R3 data", mem_data, 64'h0000_5678_0000_1234);
        @(negedge clk);
        @(negedge clk);
        check("R6 held valid", 64'(mem_valid), 64'd1);
        check("R6 held addr", 64'(mem_addr), 64'h1000);
        check("R6 held data", mem_data, 64'h0000_5678_0000_1234);
        complete();
        check("R3 released", 64'(mem_valid), 64'd0);
        event_in(3'b100, 32'h9, 32'hA);
        check("R5 next slot", 64'(mem_addr), 64'h1008);
        complete();
        store_en = 1'b0;
        event_in(3'b001, 32'h1, 32'h2);
        check("R4 no request", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_drop();
        load_buf(32'h1000, 32'h1020);
        store_en = 1'b1;
        event_in(3'b001, 32'hA1, 32'hA2);
        event_in(3'b001, 32'hB1, 32'hB2);
        check("R7 ovf count", 64'(ovf_count), 64'd1);
        check("R7 addr kept", 64'(mem_addr), 64'h1000);
        check("R7 data kept", mem_data, 64'h0000_00A2_0000_00A1);
        complete();
        event_in(3'b001, 32'hC1, 32'hC2);
        check("R7 index not advanced", 64'(mem_addr), 64'h1008);
        check("R7 new data", mem_data, 64'h0000_00C2_0000_00C1);
        complete();
        store_en = 1'b0;
    endtask

    task automatic t_circ();
        load_buf(32'h2000, 32'h2010);
        store_en = 1'b1; irq_on_full = 1'b0;
        event_in(3'b001, 32'h1, 32'h2);
        check("R10 slot0", 64'(mem_addr), 64'h2000);
        complete();
        event_in(3'b001, 32'h3, 32'h4);
        check("R10 slot1", 64'(mem_addr), 64'h2008);
        complete();
        event_in(3'b001, 32'h5, 32'h6);
        check("R10 wrapped", 64'(mem_addr), 64'h2000);
        check("R10 no irq", 64'(irq), 64'd0);
        complete();
        store_en = 1'b0;
    endtask

    task automatic t_full();
        logic [7:0] ovf_before;
        load_buf(32'h3000, 32'h3010);
        store_en = 1'b1; irq_on_full = 1'b1;
        ovf_before = ovf_count;
        event_in(3'b001, 32'h1, 32'h2);
        check("R8 not yet", 64'(irq), 64'd0);
        complete();
        event_in(3'b010, 32'h3, 32'h4);
        check("R8 last slot", 64'(mem_addr), 64'h3008);
        check("R8 irq raised", 64'(irq), 64'd1);
        complete();
        event_in(3'b001, 32'h5, 32'h6);
        check("R8 suppressed", 64'(mem_valid), 64'd0);
        check("R8 not a drop", 64'(ovf_count), 64'(ovf_before));
        repeat (3) @(negedge clk);
        check("R9 irq held", 64'(irq), 64'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R9 irq cleared", 64'(irq), 64'd0);
        load_buf(32'h3000, 32'h3010);
        event_in(3'b001, 32'h7, 32'h8);
        check("R11 reload stores", 64'(mem_valid), 64'd1);
        check("R11 reload addr", 64'(mem_addr), 64'h3000);
        complete();
        store_en = 1'b0; irq_on_full = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msg();
        t_store();
        t_drop();
        t_circ();
        t_full();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule